// File: doc/BRIEF.md
# Vertical-Interval Timecode Line Deframer

This block takes one sliced vertical-interval timecode line, delivered as a serial stream of 90 bits with a one-cycle valid strobe per bit. The line is made of 9 groups. Each group starts with a 2-bit framing pair, "1" then "0", and then carries 8 payload bits. The block checks every framing pair and drops it from the payload. It packs the payload bits into 9 bytes. It also runs an 8-bit check code over the first 82 bits of the line, framing bits included, which covers every group before the last payload byte.

When the 90th bit arrives on a line with no framing faults, the 9 bytes, the computed check value and a match flag are all loaded into the readback registers in the same cycle, and the available flag goes high. A framing fault ends the line early and leaves the readback state as it was. A one-cycle write to the clear control wipes the readback state. The control releases itself after one cycle. Bit slicing, line selection and the host register bus sit outside this block.

Top module: `vitc_deframer`

## Requirements
- R1: After reset, `tc_data`, `tc_crc`, `tc_avail`, `crc_ok` and `clr_busy` are all zero.
- R2: Line bit i is the i-th bit accepted with `bit_vld` high, counting from 0. Bits 10k and 10k+1 are the framing pair of group k. Payload byte k is bits 10k+2 to 10k+9, least significant bit first. It appears on `tc_data[8k+7:8k]`, for k = 0 to 8.
- R3: `tc_crc` holds the check value over line bits 0 to 81, fed in order of arrival. The register starts at zero. Each bit b updates it as c = {c[6:0], b ^ c[7]}, which is the generator x^8 + 1.
- R4: `tc_data`, `tc_crc`, `crc_ok` and `tc_avail` change together, exactly one clock after the edge that accepts bit 89 of a line with no framing faults, and `tc_avail` becomes 1. Before that edge they keep their previous values.
- R5: `crc_ok` is 1 after a committed line whose computed check value equals payload byte 8, and 0 after a committed line where the two differ.
- R6: If a framing pair is not "1" then "0", the line is aborted. The readback outputs, including `tc_avail`, keep their values, and further bits are ignored until `line_start`.
- R7: A one-cycle `clr_wr` pulse raises `clr_busy` for exactly one cycle. On the following edge, `tc_data`, `tc_crc`, `tc_avail` and `crc_ok` are zeroed.
- R8: Cycles with `bit_vld` low are not counted as bits, so a line sent with idle gaps between bits decodes the same as one sent without gaps.
- R9: `line_start` restarts framing, and the next strobed bit becomes bit 0. A partial line abandoned this way leaves the readback outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Begin a new line; next strobed bit is bit 0 |
| bit_vld | input | 1 | Strobe: `bit_val` carries a line bit this cycle |
| bit_val | input | 1 | Serial line bit |
| clr_wr | input | 1 | Write of 1 to the self-clearing clear control |
| tc_data | output | 72 | Nine payload bytes, byte k at bits 8k+7:8k |
| tc_crc | output | 8 | Computed check value of the last committed line |
| tc_avail | output | 1 | A line has been decoded since reset or clear |
| crc_ok | output | 1 | Computed check value matched received byte 8 |
| clr_busy | output | 1 | Clear control is active (one cycle) |

## Verification
On every cycle the assertions check several properties. The readback registers stay steady whenever no commit and no clear is in progress, which covers aborts and partial lines. A pending clear must leave the registers zeroed on the next edge. A commit may only follow the final bit of the last group. `crc_ok` may never be high without `tc_avail`. The bench scenarios cover the rest: the actual byte packing and bit order, the check value itself, the match and mismatch cases of `crc_ok`, restarting a line, and idle gaps between bits. Each of these needs a known input line and a value computed from the requirements.

// File: rtl/vitc_pkg.sv
package vitc_pkg;

    // Framer run state: accepting bits, or parked until the next line start
    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_e;

endpackage

// File: rtl/vitc_framer.sv
module vitc_framer #(
    parameter int             NGROUP   = 9,
    parameter int             BYTE_W   = 8,
    parameter int             SYNC_W   = 2,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b01
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           line_start,
    input  logic                           bit_vld,
    input  logic                           bit_val,
    output logic                           crc_en_o,
    output logic                           crc_restart_o,
    output logic                           done_o,
    output logic [NGROUP-1:0][BYTE_W-1:0]  bytes_o
);
    import vitc_pkg::*;

    localparam int GROUP_BITS = SYNC_W + BYTE_W;
    localparam int GRP_W      = (NGROUP > 1) ? $clog2(NGROUP) : 1;
    localparam int POS_W      = $clog2(GROUP_BITS);
    localparam int BI_W       = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam int SI_W       = (SYNC_W > 1) ? $clog2(SYNC_W) : 1;
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NGROUP - 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUP_BITS - 1);
    localparam logic [POS_W-1:0] SYNC_END = POS_W'(SYNC_W);

    typedef struct packed {
        fr_state_e                    state;
        logic [GRP_W-1:0]             grp;
        logic [POS_W-1:0]             pos;
        logic [BYTE_W-1:0]            sh;
        logic [NGROUP-1:0][BYTE_W-1:0] bytes;
        logic                         done;
    } fr_t;

    fr_t q, d;

    logic               take_bit;
    logic               in_sync;
    logic               sync_bad;
    logic [BI_W-1:0]    bidx;
    logic [SI_W-1:0]    sidx;
    logic [BYTE_W-1:0]  byte_nx;

    always_comb begin
        take_bit = bit_vld && !line_start && (q.state == FR_RUN);
        in_sync  = (q.pos < SYNC_END);
        sidx     = SI_W'(q.pos);
        sync_bad = in_sync && (bit_val != SYNC_PAT[sidx]);
        bidx     = BI_W'(q.pos - SYNC_END);
        byte_nx  = q.sh;
        if (!in_sync) begin
            byte_nx[bidx] = bit_val;
        end

        d      = q;
        d.done = 1'b0;

        if (line_start) begin
            d.state = FR_RUN;
            d.grp   = '0;
            d.pos   = '0;
            d.sh    = '0;
        end else if (take_bit) begin
            if (sync_bad) begin
                d.state = FR_IDLE;
            end else begin
                d.sh = byte_nx;
                if (q.pos == LAST_POS) begin
                    d.bytes[q.grp] = byte_nx;
                    d.pos          = '0;
                    if (q.grp == LAST_GRP) begin
                        d.done  = 1'b1;
                        d.state = FR_IDLE;
                    end else begin
                        d.grp = q.grp + 1'b1;
                    end
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end
        end
    end

    // Check code covers every bit ahead of the final payload byte
    always_comb begin
        crc_restart_o = line_start;
        crc_en_o      = take_bit && ((q.grp != LAST_GRP) || in_sync);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= FR_RUN;
        end else begin
            q <= d;
        end
    end

    assign done_o  = q.done;
    assign bytes_o = q.bytes;

    AST_GRP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.grp <= LAST_GRP);  // R2
    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos <= LAST_POS);  // R2
    AST_DONE_ON_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(bit_vld && q.grp == LAST_GRP && q.pos == LAST_POS));  // R4

endmodule

// File: rtl/vitc_crc.sv
module vitc_crc #(
    parameter int               CRC_W    = 8,
    parameter logic [CRC_W-1:0] CRC_POLY = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        fb    = bit_in ^ crc_q[CRC_W-1];
        crc_d = crc_q;
        if (restart) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    AST_CRC_ZERO_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> crc_q == '0);  // R3

endmodule

// File: rtl/vitc_readback.sv
module vitc_readback #(
    parameter int NGROUP = 9,
    parameter int BYTE_W = 8,
    parameter int CRC_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_wr,
    input  logic                           done_i,
    input  logic [NGROUP-1:0][BYTE_W-1:0]  bytes_i,
    input  logic [CRC_W-1:0]               crc_i,
    output logic [NGROUP*BYTE_W-1:0]       data_o,
    output logic [CRC_W-1:0]               crc_o,
    output logic                           avail_o,
    output logic                           ok_o,
    output logic                           clr_busy_o
);
    typedef struct packed {
        logic [NGROUP-1:0][BYTE_W-1:0] data;
        logic [CRC_W-1:0]              crc;
        logic                          avail;
        logic                          ok;
        logic                          clr;
    } rb_t;

    rb_t q, d;

    always_comb begin
        d     = q;
        d.clr = clr_wr && !q.clr;
        if (q.clr) begin
            d.data  = '0;
            d.crc   = '0;
            d.avail = 1'b0;
            d.ok    = 1'b0;
        end else if (done_i) begin
            d.data  = bytes_i;
            d.crc   = crc_i;
            d.avail = 1'b1;
            d.ok    = (crc_i == CRC_W'(bytes_i[NGROUP-1]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o     = q.data;
    assign crc_o      = q.crc;
    assign avail_o    = q.avail;
    assign ok_o       = q.ok;
    assign clr_busy_o = q.clr;

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !q.clr) |=> ($stable(data_o) && $stable(crc_o) && $stable(avail_o)));  // R6
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        q.clr |=> (!avail_o && !ok_o && crc_o == '0 && data_o == '0));  // R7
    AST_OK_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> avail_o);  // R5
    AST_AVAIL_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_o) |-> $past(done_i));  // R4

endmodule

// File: rtl/vitc_deframer.sv
module vitc_deframer #(
    parameter int                NGROUP   = 9,
    parameter int                BYTE_W   = 8,
    parameter int                SYNC_W   = 2,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b01,
    parameter int                CRC_W    = 8,
    parameter logic [CRC_W-1:0]  CRC_POLY = 8'h01
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_start,
    input  logic                     bit_vld,
    input  logic                     bit_val,
    input  logic                     clr_wr,
    output logic [NGROUP*BYTE_W-1:0] tc_data,
    output logic [CRC_W-1:0]         tc_crc,
    output logic                     tc_avail,
    output logic                     crc_ok,
    output logic                     clr_busy
);
    logic                          crc_en;
    logic                          crc_restart;
    logic                          done;
    logic [NGROUP-1:0][BYTE_W-1:0] bytes;
    logic [CRC_W-1:0]              crc_val;

    vitc_framer #(
        .NGROUP   (NGROUP),
        .BYTE_W   (BYTE_W),
        .SYNC_W   (SYNC_W),
        .SYNC_PAT (SYNC_PAT)
    ) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start    (line_start),
        .bit_vld       (bit_vld),
        .bit_val       (bit_val),
        .crc_en_o      (crc_en),
        .crc_restart_o (crc_restart),
        .done_o        (done),
        .bytes_o       (bytes)
    );

    vitc_crc #(
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (crc_restart),
        .en      (crc_en),
        .bit_in  (bit_val),
        .crc_o   (crc_val)
    );

    vitc_readback #(
        .NGROUP (NGROUP),
        .BYTE_W (BYTE_W),
        .CRC_W  (CRC_W)
    ) u_readback (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_wr     (clr_wr),
        .done_i     (done),
        .bytes_i    (bytes),
        .crc_i      (crc_val),
        .data_o     (tc_data),
        .crc_o      (tc_crc),
        .avail_o    (tc_avail),
        .ok_o       (crc_ok),
        .clr_busy_o (clr_busy)
    );

endmodule

// File: tb/test_vitc_deframer.sv
module test_vitc_deframer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_val = 1'b0;
    logic        clr_wr = 1'b0;
    logic [71:0] tc_data;
    logic [7:0]  tc_crc;
    logic        tc_avail;
    logic        crc_ok;
    logic        clr_busy;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #4 clk = ~clk;  // 125 MHz

    vitc_deframer i_vitc_deframer (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .bit_vld(bit_vld),
        .bit_val(bit_val), .clr_wr(clr_wr), .tc_data(tc_data), .tc_crc(tc_crc),
        .tc_avail(tc_avail), .crc_ok(crc_ok), .clr_busy(clr_busy)
    );

    task automatic chk(input bit cond, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_run++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [89:0] build_line(input logic [71:0] bytes);
        logic [89:0] lb;
        for (int g = 0; g < 9; g++) begin
            lb[10*g]     = 1'b1;
            lb[10*g + 1] = 1'b0;
            for (int b = 0; b < 8; b++) lb[10*g + 2 + b] = bytes[8*g + b];
        end
        return lb;
    endfunction

    function automatic logic [7:0] model_crc(input logic [89:0] lb);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 82; i++) c = {c[6:0], lb[i] ^ c[7]};
        return c;
    endfunction

    task automatic pulse_start();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic send_bits(input logic [89:0] lb, input int first, input int last, input int gap);
        for (int i = first; i <= last; i++) begin
            bit_vld = 1'b1;
            bit_val = lb[i];
            @(negedge clk);
            bit_vld = 1'b0;
            bit_val = ~lb[i];
            for (int k = 0; k < gap; k++) @(negedge clk);
        end
    endtask

    task automatic check_regs(input string req, input logic [71:0] ed, input logic [7:0] ec,
                              input logic ea, input logic eo);
        chk(tc_data == ed, req, tc_data, ed);
        chk(tc_crc == ec, req, 72'(tc_crc), 72'(ec));
        chk(tc_avail == ea, req, 72'(tc_avail), 72'(ea));
        chk(crc_ok == eo, req, 72'(crc_ok), 72'(eo));
    endtask

    logic [71:0] held_data;
    logic [7:0]  held_crc;
    logic        held_ok;

    // R1: reset state
    task automatic t_reset();
        check_regs("R1", 72'h0, 8'h00, 1'b0, 1'b0);
        chk(clr_busy == 1'b0, "R1", 72'(clr_busy), 72'h0);
    endtask

    // R2 R3 R4 R5: good line, mismatching final byte, commit timing
    task automatic t_good_line();
        logic [71:0] by = 72'hA5_3C_01_FF_80_7E_12_C3_96;
        logic [89:0] lb = build_line(by);
        logic [7:0]  ec = model_crc(lb);
        if (by[71:64] == ec) by[71:64] = ~ec;
        lb = build_line(by);
        pulse_start();
        send_bits(lb, 0, 88, 0);
        check_regs("R4 before last bit", 72'h0, 8'h00, 1'b0, 1'b0);
        send_bits(lb, 89, 89, 0);
        chk(tc_avail == 1'b0, "R4 one cycle latency", 72'(tc_avail), 72'h0);
        @(negedge clk);
        chk(tc_data == by, "R2", tc_data, by);
        chk(tc_crc == ec, "R3", 72'(tc_crc), 72'(ec));
        chk(tc_avail == 1'b1, "R4", 72'(tc_avail), 72'h1);
        chk(crc_ok == 1'b0, "R5 mismatch", 72'(crc_ok), 72'h0);
    endtask

    // R5: final byte equals computed check value
    task automatic t_crc_match();
        logic [71:0] by = 72'h00_5A_6B_7C_8D_9E_AF_B0_C1;
        logic [89:0] lb = build_line(by);
        logic [7:0]  ec = model_crc(lb);
        by[71:64] = ec;
        lb = build_line(by);
        pulse_start();
        send_bits(lb, 0, 89, 0);
        @(negedge clk);
        check_regs("R5 match", by, ec, 1'b1, 1'b1);
        held_data = by; held_crc = ec; held_ok = 1'b1;
    endtask

    // R6: framing fault in a middle group, and stray bits afterwards
    task automatic t_bad_sync();
        logic [71:0] by = 72'h11_22_33_44_55_66_77_88_99;
        logic [89:0] lb = build_line(by);
        lb[41] = 1'b1;  // group 4 second framing bit wrong
        pulse_start();
        send_bits(lb, 0, 89, 0);
        @(negedge clk);
        check_regs("R6 bad sync holds", held_data, held_crc, 1'b1, held_ok);
        lb = build_line(by);
        send_bits(lb, 0, 89, 0);  // no line_start: ignored
        @(negedge clk);
        chk(tc_data == held_data, "R6 ignored until line_start", tc_data, held_data);
    endtask

    // R7: clear control
    task automatic t_clear();
        clr_wr = 1'b1;
        @(negedge clk);
        clr_wr = 1'b0;
        chk(clr_busy == 1'b1, "R7 busy set", 72'(clr_busy), 72'h1);
        @(negedge clk);
        chk(clr_busy == 1'b0, "R7 self clears", 72'(clr_busy), 72'h0);
        check_regs("R7 cleared", 72'h0, 8'h00, 1'b0, 1'b0);
    endtask

    // R6: fault in the last group's first framing bit with avail at 0
    task automatic t_bad_last_group();
        logic [89:0] lb = build_line(72'hDE_AD_BE_EF_01_23_45_67_89);
        lb[80] = 1'b0;
        pulse_start();
        send_bits(lb, 0, 89, 0);
        @(negedge clk);
        check_regs("R6 avail stays 0", 72'h0, 8'h00, 1'b0, 1'b0);
    endtask

    // R8: idle gaps between strobed bits
    task automatic t_gaps();
        logic [71:0] by = 72'h3F_E1_0C_77_B4_29_D8_65_4A;
        logic [89:0] lb = build_line(by);
        logic [7:0]  ec = model_crc(lb);
        pulse_start();
        send_bits(lb, 0, 89, 2);
        check_regs("R8 gaps", by, ec, 1'b1, ec == by[71:64]);
    endtask

    // R9: abandoned partial line then restart
    task automatic t_restart();
        logic [71:0] jb = 72'hFF_FF_FF_FF_FF_FF_FF_FF_FF;
        logic [71:0] by = 72'h02_13_24_35_46_57_68_79_8A;
        logic [89:0] jl = build_line(jb);
        logic [89:0] lb = build_line(by);
        logic [7:0]  ec = model_crc(lb);
        logic [71:0] pd = tc_data;
        pulse_start();
        send_bits(jl, 0, 46, 0);
        @(negedge clk);
        chk(tc_data == pd, "R9 partial line no effect", tc_data, pd);
        pulse_start();
        send_bits(lb, 0, 89, 0);
        @(negedge clk);
        check_regs("R9 restart", by, ec, 1'b1, ec == by[71:64]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_line();
        t_crc_match();
        t_bad_sync();
        t_clear();
        t_bad_last_group();
        t_gaps();
        t_restart();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule